// File: doc/BRIEF.md
# Flash Bank Status Tracker

This block keeps the status byte of one bank in a two-bank flash scheme that stands in for a byte-writable non-volatile store. The status byte is a one-way thermometer: each step clears exactly one more bit, so the flash can move forward by incremental programming and never needs an erase to record progress. Event strobes report how the bank handover is going. They cover the start and end of the erase of the other bank, the start and end of programming new data into it, and the final swap. The block checks that each strobe arrives in order, produces the next byte to program, and holds a request and busy handshake until the flash controller confirms the write.

At power-up the same block decodes the two stored bank bytes into a choice of active bank. Bytes that are not part of the code set are flagged as corrupt. A small combinational decoder also classifies the 2-bit per-record status and gives the next record status in its own clear-only chain.

Top module: `bank_status_tracker`

## Requirements
- R1: After reset, prog_data is 8'h7F (this bank active), and prog_req, busy and illegal_event are all 0.
- R2: The codes in order are 7F, 3F, 1F, 0F, 07, 03. ev_kind 0 (erase of other bank started) moves 7F to 3F. Kind 1 (that erase finished) moves 3F to 1F. Kind 2 (programming of other bank started) moves 1F to 0F. Kind 3 (that programming finished) moves 0F to 07. Kind 4 (swap, other bank active) moves 07 to 03. A strobe is accepted only when the stored code is the one listed just before its target.
- R3: For an accepted strobe sampled at edge N, edge N+1 shows the new prog_data, prog_req high for exactly one cycle, and busy high. busy stays high until the edge after prog_done is sampled high.
- R4: A strobe that is out of order, has ev_kind 5 to 7, or arrives while busy is high raises illegal_event for one cycle at the next edge. In that case prog_data does not change, prog_req stays low and busy is not changed.
- R5: prog_data only ever clears bits; a change never sets a bit back to 1.
- R6: A stored bank byte is legal when it is one of the six codes or 8'hFF (erased). dec_bad[0] flags an illegal byte on bank A, and dec_bad[1] flags one on bank B.
- R7: When exactly one bank holds 8'h03, the other bank is chosen (dec_bank 0 = A, 1 = B). This holds even when the other bank's byte is illegal.
- R8: If R7 does not apply, the bank that alone holds one of the codes 7F, 3F, 1F, 0F or 07 is chosen. In every other case dec_none is 1 and dec_bank is 0. Results appear with a one-cycle dec_done pulse at the edge after dec_req and hold until the next request.
- R9: ds_state decodes ds_code 11 as 0 (virgin), 01 as 1 (valid), 00 as 2 (dirty) and 10 as 3 (reserved). ds_next gives 11 to 01, 01 to 00, 00 to 00 and 10 to 10. Both outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | One-cycle event strobe |
| ev_kind | input | 3 | Event code, see R2 |
| prog_done | input | 1 | Flash controller finished the status write |
| prog_req | output | 1 | One-cycle request to program prog_data |
| prog_data | output | 8 | Current status byte, the value to program |
| busy | output | 1 | Write outstanding |
| illegal_event | output | 1 | Rejected strobe, one cycle |
| dec_req | input | 1 | Start power-up decode |
| code_a | input | 8 | Stored status byte of bank A |
| code_b | input | 8 | Stored status byte of bank B |
| dec_done | output | 1 | Decode result valid pulse |
| dec_bank | output | 1 | Chosen bank, 0 = A, 1 = B |
| dec_none | output | 1 | No bank could be chosen |
| dec_bad | output | 2 | Illegal byte flags, bit 0 A, bit 1 B |
| ds_code | input | 2 | Stored 2-bit record status |
| ds_state | output | 2 | Decoded record state |
| ds_next | output | 2 | Next record status to program |

## Verification
For every strobe, the scoreboard queues the expected prog_req, prog_data, busy and illegal_event values with a due cycle one edge after the strobe. For accepted strobes it also queues a second entry one edge later, where prog_req must be low again while busy stays high. A prog_done entry expects busy to be low one edge later. The monitor compares entries only at the falling edge of the due cycle. Decode results are sampled at the falling edge after the one edge that registers dec_req, and the record decoder is sampled after its inputs settle.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [1:0] {
        DS_VIRGIN = 2'd0,
        DS_VALID  = 2'd1,
        DS_DIRTY  = 2'd2,
        DS_RSVD   = 2'd3
    } ds_state_e;

    typedef enum logic [2:0] {
        EV_ERASE_GO  = 3'd0,
        EV_ERASE_END = 3'd1,
        EV_PROG_GO   = 3'd2,
        EV_PROG_END  = 3'd3,
        EV_SWAP      = 3'd4
    } ev_kind_e;

    // Thermometer step k of a w-bit status byte: top k+1 bits cleared.
    function automatic logic [31:0] step_value(int w, int k);
        return (32'd1 << (w - 1 - k)) - 32'd1;
    endfunction

endpackage

// File: rtl/bst_seq.sv
module bst_seq
    import bst_pkg::*;
#(
    parameter int W     = 8,
    parameter int STEPS = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_valid,
    input  logic [$clog2(STEPS)-1:0] ev_kind,
    input  logic                     prog_done,
    output logic                     prog_req,
    output logic [W-1:0]             prog_data,
    output logic                     busy,
    output logic                     illegal_event
);
    localparam int KW = $clog2(STEPS);

    typedef struct packed {
        logic [W-1:0] code;
        logic         req;
        logic         busy;
        logic         illegal;
    } seq_t;

    logic [W-1:0] step_tab [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_tab
        assign step_tab[k] = W'(step_value(W, k));
    end

    seq_t s_d, s_q;
    logic         hit;
    logic [W-1:0] nxt;

    always_comb begin
        hit = 1'b0;
        nxt = s_q.code;
        for (int k = 0; k < STEPS - 1; k++) begin
            if (ev_kind == KW'(k) && s_q.code == step_tab[k]) begin
                hit = 1'b1;
                nxt = step_tab[k+1];
            end
        end

        s_d         = s_q;
        s_d.req     = 1'b0;
        s_d.illegal = 1'b0;
        if (s_q.busy && prog_done) begin
            s_d.busy = 1'b0;
        end
        if (ev_valid) begin
            if (!s_q.busy && hit) begin
                s_d.code = nxt;
                s_d.req  = 1'b1;
                s_d.busy = 1'b1;
            end else begin
                s_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.code    <= W'(step_value(W, 0));
            s_q.req     <= 1'b0;
            s_q.busy    <= 1'b0;
            s_q.illegal <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign prog_req      = s_q.req;
    assign prog_data     = s_q.code;
    assign busy          = s_q.busy;
    assign illegal_event = s_q.illegal;

endmodule

// File: rtl/bst_boot.sv
module bst_boot
    import bst_pkg::*;
#(
    parameter int W     = 8,
    parameter int STEPS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_req,
    input  logic [W-1:0] code_a,
    input  logic [W-1:0] code_b,
    output logic         dec_done,
    output logic         dec_bank,
    output logic         dec_none,
    output logic [1:0]   dec_bad
);
    typedef struct packed {
        logic       done;
        logic       bank;
        logic       none;
        logic [1:0] bad;
    } boot_t;

    logic [W-1:0] step_tab [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_tab
        assign step_tab[k] = W'(step_value(W, k));
    end

    // Per-bank classification: owner codes, handover code, legality.
    logic [1:0] own, hand, legal;
    logic [W-1:0] pick [2];
    assign pick[0] = code_a;
    assign pick[1] = code_b;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_comb begin
            own[b] = 1'b0;
            for (int k = 0; k < STEPS - 1; k++) begin
                if (pick[b] == step_tab[k]) own[b] = 1'b1;
            end
            hand[b]  = (pick[b] == step_tab[STEPS-1]);
            legal[b] = own[b] || hand[b] || (pick[b] == {W{1'b1}});
        end
    end

    boot_t b_d, b_q;

    always_comb begin
        b_d      = b_q;
        b_d.done = 1'b0;
        if (dec_req) begin
            b_d.done = 1'b1;
            b_d.bad  = ~legal;
            b_d.bank = 1'b0;
            b_d.none = 1'b0;
            if (hand[0] && !hand[1]) begin
                b_d.bank = 1'b1;
            end else if (hand[1] && !hand[0]) begin
                b_d.bank = 1'b0;
            end else if (!hand[0] && !hand[1] && own[0] && !own[1]) begin
                b_d.bank = 1'b0;
            end else if (!hand[0] && !hand[1] && own[1] && !own[0]) begin
                b_d.bank = 1'b1;
            end else begin
                b_d.none = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign dec_done = b_q.done;
    assign dec_bank = b_q.bank;
    assign dec_none = b_q.none;
    assign dec_bad  = b_q.bad;

endmodule

// File: rtl/bst_ds.sv
module bst_ds
    import bst_pkg::*;
(
    input  logic [1:0] ds_code,
    output logic [1:0] ds_state,
    output logic [1:0] ds_next
);
    ds_state_e st;

    always_comb begin
        unique case (ds_code)
            2'b11:   begin st = DS_VIRGIN; ds_next = 2'b01; end
            2'b01:   begin st = DS_VALID;  ds_next = 2'b00; end
            2'b00:   begin st = DS_DIRTY;  ds_next = 2'b00; end
            default: begin st = DS_RSVD;   ds_next = 2'b10; end
        endcase
    end

    assign ds_state = st;

endmodule

// File: rtl/bank_status_tracker.sv
module bank_status_tracker #(
    parameter int W     = 8,
    parameter int STEPS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_valid,
    input  logic [2:0]   ev_kind,
    input  logic         prog_done,
    output logic         prog_req,
    output logic [7:0]   prog_data,
    output logic         busy,
    output logic         illegal_event,
    input  logic         dec_req,
    input  logic [7:0]   code_a,
    input  logic [7:0]   code_b,
    output logic         dec_done,
    output logic         dec_bank,
    output logic         dec_none,
    output logic [1:0]   dec_bad,
    input  logic [1:0]   ds_code,
    output logic [1:0]   ds_state,
    output logic [1:0]   ds_next
);
    localparam int KW = $clog2(STEPS);

    logic [W-1:0] pd_w;

    bst_seq #(.W(W), .STEPS(STEPS)) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_valid      (ev_valid),
        .ev_kind       (KW'(ev_kind)),
        .prog_done     (prog_done),
        .prog_req      (prog_req),
        .prog_data     (pd_w),
        .busy          (busy),
        .illegal_event (illegal_event)
    );

    assign prog_data = 8'(pd_w);

    bst_boot #(.W(W), .STEPS(STEPS)) i_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_req  (dec_req),
        .code_a   (W'(code_a)),
        .code_b   (W'(code_b)),
        .dec_done (dec_done),
        .dec_bank (dec_bank),
        .dec_none (dec_none),
        .dec_bad  (dec_bad)
    );

    bst_ds i_ds (
        .ds_code  (ds_code),
        .ds_state (ds_state),
        .ds_next  (ds_next)
    );

endmodule

// File: rtl/bst_chk.sv
module bst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_valid,
    input logic       prog_done,
    input logic       prog_req,
    input logic [7:0] prog_data,
    input logic       busy,
    input logic       illegal_event,
    input logic       dec_req,
    input logic       dec_done
);
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> busy);

    p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_done));

    p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prog_data) |-> ((prog_data & ~$past(prog_data)) == 8'h00));

    p_illegal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_event |-> ($stable(prog_data) && !prog_req));

    p_illegal_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_event |-> $past(ev_valid));

    p_dec_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |-> $past(dec_req));

endmodule

bind bank_status_tracker bst_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_valid      (ev_valid),
    .prog_done     (prog_done),
    .prog_req      (prog_req),
    .prog_data     (prog_data),
    .busy          (busy),
    .illegal_event (illegal_event),
    .dec_req       (dec_req),
    .dec_done      (dec_done)
);

// File: tb/test_bank_status_tracker.sv
module test_bank_status_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [2:0] ev_kind = 3'd0;
    logic       prog_done = 1'b0;
    logic       prog_req;
    logic [7:0] prog_data;
    logic       busy;
    logic       illegal_event;
    logic       dec_req = 1'b0;
    logic [7:0] code_a = 8'hFF;
    logic [7:0] code_b = 8'hFF;
    logic       dec_done;
    logic       dec_bank;
    logic       dec_none;
    logic [1:0] dec_bad;
    logic [1:0] ds_code = 2'b11;
    logic [1:0] ds_state;
    logic [1:0] ds_next;

    always #5 clk = ~clk;

    bank_status_tracker i_bank_status_tracker (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .prog_done(prog_done), .prog_req(prog_req), .prog_data(prog_data),
        .busy(busy), .illegal_event(illegal_event), .dec_req(dec_req),
        .code_a(code_a), .code_b(code_b), .dec_done(dec_done),
        .dec_bank(dec_bank), .dec_none(dec_none), .dec_bad(dec_bad),
        .ds_code(ds_code), .ds_state(ds_state), .ds_next(ds_next)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    typedef struct {
        int         due;
        logic       req;
        logic [7:0] data;
        logic       bsy;
        logic       ill;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [7:0] tb_code = 8'h7F;
    logic       tb_busy = 1'b0;
    logic [7:0] last_pd = 8'h7F;
    bit         mon_on  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares scoreboard entries in their due cycle.
    always @(negedge clk) begin
        if (mon_on) begin
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " prog_req"},      32'(prog_req),      32'(e.req));
                check({e.tag, " prog_data"},     32'(prog_data),     32'(e.data));
                check({e.tag, " busy"},          32'(busy),          32'(e.bsy));
                check({e.tag, " illegal_event"}, 32'(illegal_event), 32'(e.ill));
            end
            if (prog_data !== last_pd) begin
                check("R5 clear-only", 32'((prog_data & ~last_pd) == 8'h00), 32'd1);
                last_pd = prog_data;
            end
        end
    end

    function automatic logic [7:0] step_of(int k);
        return 8'hFF >> (k + 1);
    endfunction

    // Driver: one strobe, expectation computed from R2/R3/R4.
    task automatic send_ev(int kind, string tag);
        bit   ok;
        exp_t e;
        ok = !tb_busy && kind < 5 && tb_code == step_of(kind);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = 3'(kind);
        e.due = cyc + 1;
        e.tag = tag;
        if (ok) begin
            tb_code = step_of(kind + 1);
            e.req = 1'b1; e.data = tb_code; e.bsy = 1'b1; e.ill = 1'b0;
            sb.push_back(e);
            e.due = cyc + 2; e.req = 1'b0;
            sb.push_back(e);
            tb_busy = 1'b1;
        end else begin
            e.req = 1'b0; e.data = tb_code; e.bsy = tb_busy; e.ill = 1'b1;
            sb.push_back(e);
        end
        @(negedge clk);
        ev_valid = 1'b0;
        if (ok) @(negedge clk);
    endtask

    task automatic finish_prog(string tag);
        exp_t e;
        @(negedge clk);
        prog_done = 1'b1;
        e.due = cyc + 1; e.req = 1'b0; e.data = tb_code; e.bsy = 1'b0; e.ill = 1'b0;
        e.tag = tag;
        sb.push_back(e);
        tb_busy = 1'b0;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic boot(logic [7:0] a, logic [7:0] b, logic eb, logic en,
                        logic [1:0] ebad, string tag);
        @(negedge clk);
        code_a  = a;
        code_b  = b;
        dec_req = 1'b1;
        @(negedge clk);
        dec_req = 1'b0;
        check({tag, " dec_done"}, 32'(dec_done), 32'd1);
        check({tag, " dec_bank"}, 32'(dec_bank), 32'(eb));
        check({tag, " dec_none"}, 32'(dec_none), 32'(en));
        check({tag, " dec_bad"},  32'(dec_bad),  32'(ebad));
        @(negedge clk);
        check({tag, " dec_done pulse"}, 32'(dec_done), 32'd0);
        check({tag, " dec_bank hold"}, 32'(dec_bank), 32'(eb));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 prog_data", 32'(prog_data), 32'h7F);
        check("R1 prog_req", 32'(prog_req), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 illegal_event", 32'(illegal_event), 32'd0);
        mon_on = 1'b1;

        send_ev(1, "R4 out of order at 7F");
        send_ev(0, "R2 erase start");
        send_ev(1, "R4 strobe while busy");
        finish_prog("R3 busy release");
        send_ev(1, "R2 erase end");
        finish_prog("R3 release 2");
        send_ev(3, "R4 skipped step");
        send_ev(2, "R2 prog start");
        finish_prog("R3 release 3");
        send_ev(3, "R2 prog end");
        finish_prog("R3 release 4");
        send_ev(4, "R2 swap");
        finish_prog("R3 release 5");
        send_ev(4, "R4 swap after end");
        send_ev(6, "R4 unused kind");
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb.size()), 32'd0);
        check("R2 final code", 32'(prog_data), 32'h03);

        boot(8'h7F, 8'hFF, 1'b0, 1'b0, 2'b00, "R8 A owner");
        boot(8'hFF, 8'h0F, 1'b1, 1'b0, 2'b00, "R8 B owner");
        boot(8'h03, 8'h7F, 1'b1, 1'b0, 2'b00, "R7 A handed over");
        boot(8'h07, 8'h03, 1'b0, 1'b0, 2'b00, "R7 B handed over");
        boot(8'h03, 8'h55, 1'b1, 1'b0, 2'b10, "R7 R6 other corrupt");
        boot(8'h7F, 8'h3F, 1'b0, 1'b1, 2'b00, "R8 both owners");
        boot(8'hFF, 8'hFF, 1'b0, 1'b1, 2'b00, "R8 both erased");
        boot(8'h03, 8'h03, 1'b0, 1'b1, 2'b00, "R8 both handed over");
        boot(8'h5A, 8'h1F, 1'b1, 1'b0, 2'b01, "R6 A corrupt");
        boot(8'h7E, 8'hBF, 1'b0, 1'b1, 2'b11, "R6 both corrupt");

        for (int i = 0; i < 4; i++) begin
            logic [1:0] c;
            logic [1:0] es;
            logic [1:0] en;
            c = 2'(i);
            case (c)
                2'b11:   begin es = 2'd0; en = 2'b01; end
                2'b01:   begin es = 2'd1; en = 2'b00; end
                2'b00:   begin es = 2'd2; en = 2'b00; end
                default: begin es = 2'd3; en = 2'b10; end
            endcase
            @(negedge clk);
            ds_code = c;
            #1;
            check("R9 ds_state", 32'(ds_state), 32'(es));
            check("R9 ds_next", 32'(ds_next), 32'(en));
        end

        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule